// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the rest of a storage device into an interrupt status register that software clears by writing ones. The events sit at fixed, sparse bit positions, and some positions are unused holes. A mask register uses the same layout, and a mask bit set to 1 silences its event. A control register holds a global interrupt enable. From this state the block drives a level interrupt line to the host.

The block can also emit message-signalled interrupts. When an event that has a message code newly sets its status bit, and that bit is unmasked and interrupts are enabled, a code is queued. Queued codes leave one per cycle, lowest status bit first, on a valid/code output pair.

Register access is a simple port. A write strobe, an address, and write data all act on the clock edge. Read data is a combinational function of the address.

Top module: `host_irq_ctl`

## Requirements
- R1: A pulse on `evt_in[i]` sets status bit i at the next clock edge for each live position i: 0 firmware state change, 1 completion posted, 2 message from device, 5..8 queue 0..3 full, 9 command FIFO overrun, 10 bad expansion-ROM read.
- R2: A write to address 0 (status) clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: Positions 3 and 4 and bits 31..11 of status and mask never set, always read 0, and ignore writes and event pulses. Address 3 reads 0.
- R5: Address 1 is the mask register. It is read/write with the same live bit layout as status and is 0 after reset.
- R6: Address 2 is the control register. Bit 7 is the global interrupt enable, and all other bits read 0.
- R7: `irq_o` is high exactly when the enable is set and some status bit is set while its mask bit is 0.
- R8: The message codes are: status bit 0 gives code 4, bit 1 gives 5, bit 2 gives 6, and bits 5..8 give 9..12. Bits 9 and 10 produce no message.
- R9: A code is queued when its event newly sets a status bit that was 0, that bit is unmasked, and the enable is set. Queued codes appear on `msi_valid`/`msi_code` one per cycle, lowest bit first, starting the cycle after the event.
- R10: Masked events, events while disabled, and events on bits already set queue no code.
- R11: After reset, status, mask and enable are 0, and `irq_o` and `msi_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 11 | Event pulses, one per status position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt to host |
| msi_valid | output | 1 | A message code is presented this cycle |
| msi_code | output | 4 | Message code |

## Verification
The two functions that can land in the same cycle are an event pulse and a status write that clears the same bit. The bench provokes this with a directed cycle that drives both together, then reads the status back through the register port to confirm the bit stayed set. A long stretch of random events and random register writes also produces many such overlaps, along with overlaps where new message codes queue while older ones are still draining. A behavioural reference model judges every clock on the interrupt line, the message outputs and the read data.

// File: rtl/host_irq_ctl.sv
module host_irq_ctl #(
  parameter int DW = 32,
  parameter int NEV = 11,
  parameter int AW = 2,
  parameter int EN_BIT = 7,
  parameter int CW = 4,
  parameter int CODE_BASE = 4,
  parameter logic [NEV-1:0] LIVE = 11'h7E7,
  parameter logic [NEV-1:0] MSI_SRC = 11'h1E7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_in,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq_o,
  output logic           msi_valid,
  output logic [CW-1:0]  msi_code
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);

  logic [NEV-1:0] stat_q, mask_q, pend_q, grant, hit, fresh, clr;
  logic en_q;
  logic wr_st, wr_mk, wr_ctl;
  logic unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata};
  assign wr_st  = reg_we && (reg_addr == A_STAT);
  assign wr_mk  = reg_we && (reg_addr == A_MASK);
  assign wr_ctl = reg_we && (reg_addr == A_CTRL);

  assign hit   = evt_in & LIVE;
  assign fresh = hit & MSI_SRC & ~stat_q & ~mask_q & {NEV{en_q}};
  assign clr   = wr_st ? reg_wdata[NEV-1:0] : '0;
  assign grant = pend_q & (~pend_q + NEV'(1));

  assign irq_o     = en_q & (|(stat_q & ~mask_q));
  assign msi_valid = |pend_q;

  always_comb begin
    msi_code = '0;
    for (int i = 0; i < NEV; i++)
      if (grant[i]) msi_code = CW'(CODE_BASE + i);
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = DW'(stat_q);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_CTRL:  reg_rdata = DW'(en_q) << EN_BIT;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      pend_q <= (pend_q & ~grant) | fresh;
      if (wr_mk)  mask_q <= reg_wdata[NEV-1:0] & LIVE;
      if (wr_ctl) en_q   <= reg_wdata[EN_BIT];
    end
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && |(reg_wdata[NEV-1:0] & ~hit)) |=> ((stat_q & $past(reg_wdata[NEV-1:0] & ~hit)) == '0));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && |(reg_wdata[NEV-1:0] & hit)) |=> ((stat_q & $past(reg_wdata[NEV-1:0] & hit)) == $past(reg_wdata[NEV-1:0] & hit)));

  assert_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DW-1:NEV] == '0) && ((reg_addr == AW'(3)) -> (reg_rdata == '0)));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_o);

  assert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |-> (msi_code >= CW'(CODE_BASE)) && MSI_SRC[msi_code - CW'(CODE_BASE)]);
endmodule

// File: tb/host_irq_ctl_test.sv
`timescale 1ns/1ps
module host_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt_in = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, msi_valid;
  logic [3:0]  msi_code;

  int checks = 0, failures = 0;
  bit done = 0;
  int codes[$];

  bit [10:0] m_st, m_mk, m_pd;
  bit        m_en;
  localparam bit [10:0] LIVE = 11'h7E7;
  localparam bit [10:0] HAS_MSG = 11'h1E7;

  always #4 clk = ~clk;

  host_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .msi_valid(msi_valid), .msi_code(msi_code)
  );

  function automatic int low_bit(bit [10:0] v);
    for (int i = 0; i < 11; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_mk = '0; m_pd = '0; m_en = 0;
    end else begin
      bit [10:0] newp, gr;
      int lb;
      lb = low_bit(m_pd);
      gr = (lb >= 0) ? (11'd1 << lb) : '0;
      newp = evt_in & LIVE & HAS_MSG & ~m_st & ~m_mk & {11{m_en}};
      m_pd = (m_pd & ~gr) | newp;
      if (reg_we && reg_addr == 2'd0) m_st = m_st & ~reg_wdata[10:0];
      m_st = m_st | (evt_in & LIVE);
      if (reg_we && reg_addr == 2'd1) m_mk = reg_wdata[10:0] & LIVE;
      if (reg_we && reg_addr == 2'd2) m_en = reg_wdata[7];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_rd;
      int lb;
      case (reg_addr)
        2'd0: exp_rd = {21'd0, m_st};
        2'd1: exp_rd = {21'd0, m_mk};
        2'd2: exp_rd = {24'd0, m_en, 7'd0};
        default: exp_rd = '0;
      endcase
      check("R7 irq model", irq_o, m_en && |(m_st & ~m_mk));
      check("R9 msi_valid model", msi_valid, m_pd != 0);
      lb = low_bit(m_pd);
      if (m_pd != 0) check("R8 msi_code model", msi_code, lb + 4);
      check("R1 rdata model", reg_rdata, exp_rd);
      if (msi_valid) codes.push_back(int'(msi_code));
    end
  end

  task automatic cyc(logic [10:0] e, logic we, logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    evt_in = e; reg_we = we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc('0, 0, reg_addr, '0);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    cyc('0, 0, a, '0);
    #1 check(req, reg_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd(2'd0, 0, "R11 status reset");
    rd(2'd1, 0, "R11 mask reset");
    rd(2'd2, 0, "R11 ctrl reset");
    check("R11 irq reset", irq_o, 0);
    check("R11 msi reset", msi_valid, 0);

    cyc('0, 1, 2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h80, "R6 ctrl only bit 7");
    cyc('0, 1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h7E7, "R5 R4 mask live bits");
    cyc('0, 1, 2'd1, 32'h0);
    rd(2'd3, 0, "R4 address 3 zero");

    codes.delete();
    cyc(11'h7FF, 0, 2'd0, 0);
    rd(2'd0, 32'h7E7, "R1 R4 all events");
    idle(10);
    check("R9 msi count", codes.size(), 7);
    foreach (codes[i]) begin
      int expc[7] = '{4, 5, 6, 9, 10, 11, 12};
      if (i < 7) check("R8 R9 msi order", codes[i], expc[i]);
    end
    check("R7 irq on", irq_o, 1);
    cyc('0, 1, 2'd1, 32'h7E7);
    idle(1);
    check("R7 irq masked", irq_o, 0);
    cyc('0, 1, 2'd1, 32'h0);

    cyc('0, 1, 2'd0, 32'h0000_0003);
    rd(2'd0, 32'h7E4, "R2 w1c partial");
    cyc(11'h001, 1, 2'd0, 32'h0000_0001);
    rd(2'd0, 32'h7E5, "R3 set wins");
    cyc('0, 1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 0, "R2 clear all");

    codes.delete();
    cyc('0, 1, 2'd1, 32'h2);
    cyc(11'h002, 0, 2'd0, 0);
    idle(3);
    check("R10 masked no msi", codes.size(), 0);
    check("R7 masked no irq", irq_o, 0);
    cyc('0, 1, 2'd1, 32'h0);
    cyc('0, 1, 2'd2, 32'h0);
    cyc(11'h001, 0, 2'd0, 0);
    idle(3);
    check("R10 disabled no msi", codes.size(), 0);
    check("R7 disabled no irq", irq_o, 0);
    cyc('0, 1, 2'd2, 32'h80);
    cyc(11'h001, 0, 2'd0, 0);
    cyc(11'h200, 0, 2'd0, 0);
    idle(3);
    check("R10 already set or no code", codes.size(), 0);
    check("R7 bit9 irq", irq_o, 1);
    cyc(11'h018, 0, 2'd0, 0);
    rd(2'd0, 32'h203, "R4 reserved events ignored");

    for (int n = 0; n < 600; n++) begin
      logic [10:0] e;
      logic we;
      e = 11'($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      cyc(e, we, 2'($urandom), (($urandom % 8) == 0) ? 32'h0 : $urandom);
    end
    idle(15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule